// File: doc/BRIEF.md
# Quad Wiper Register Bank

This block holds the digital state of four potentiometer channels. Each channel keeps an 8-bit wiper code, which sets the tap in use, plus four 8-bit data registers that stand in for nonvolatile storage. A serial front end decodes the bus traffic and passes this block one parallel command per cycle. Each command has an opcode, a channel number, a register number and a data byte. The block drives a one-hot select of 256 lines per channel, returns read data one cycle after the command, and shows a write-in-progress flag.

Four paths load the wiper code: a direct write, a copy from one data register of the same channel, a copy that hits every channel in the same cycle, and a single step up or down. A data register write is only armed when it is received. It is stored when the front end reports the rising edge of chip select (`cs_rise`). The store then starts a busy period of `BUSY_CYCLES` clocks. A low `wp_n` blocks data register stores but never wiper writes.

The controller FSM has four states. RECALL lasts the first cycle after reset and copies data register 0 of each channel into its wiper. IDLE accepts commands. ARMED holds one pending data register write. BUSY counts the store time. The transitions are:
- BOOT_DONE: RECALL to IDLE.
- ARM: IDLE to ARMED, on an accepted data register write.
- COMMIT: ARMED to BUSY, on `cs_rise` while `wp_n` is high.
- DISCARD: ARMED to IDLE, on `cs_rise` while `wp_n` is low.
- RELEASE: BUSY to IDLE, when the busy counter reaches zero.

Top module: `quad_wiper_bank`

## Requirements
- R1: In reset, `wip` and `rsp_valid` are low. After reset, data register r of channel c holds INIT_BASE + 16*c + r (INIT_BASE defaults to 40h). Each wiper holds its channel's register-0 value from the second clock after reset release.
- R2: For each channel c, the slice `tap_sel[c*256 +: 256]` has exactly one bit set, at the index equal to the wiper code. Code 00h selects line 0 (low end) and FFh selects line 255 (high end).
- R3: Write-wiper (opcode Ah) loads `cmd_data` into the wiper of channel `cmd_pot` on the next clock. It works whatever the state of `wp_n` and `wip`.
- R4: Step (opcode 2h) moves the wiper of `cmd_pot` up by one when `cmd_data[0]`=1 and down by one when it is 0. The code holds at FFh going up and at 00h going down.
- R5: Transfer (opcode Dh) copies data register `cmd_reg` of channel `cmd_pot` into that channel's wiper. Global transfer (opcode 1h) copies register `cmd_reg` of every channel into its own wiper in the same clock.
- R6: Read-wiper (9h), read-register (Bh) and read-status (5h) each give one `rsp_valid` pulse on the clock after the command. `rsp_data` carries the wiper code, the addressed data register, or `wip` in bit 0 with the other bits zero.
- R7: Write-register (opcode Ch) does not change the register until `cs_rise`. A later write-register received before `cs_rise` replaces the pending one.
- R8: A committed store raises `wip` on the clock that samples `cs_rise`, and `wip` stays high for exactly BUSY_CYCLES clocks.
- R9: With `wp_n` low, either when write-register arrives or at `cs_rise`, the register is left unchanged and `wip` does not rise.
- R10: While `wip` is high, write-register, transfer and global transfer are ignored. Reads, write-wiper and step still act.
- R11: A `cs_rise` with no pending write has no effect and leaves `wip` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models power-up |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Opcode |
| cmd_pot | input | 2 | Channel number |
| cmd_reg | input | 2 | Data register number |
| cmd_data | input | 8 | Write data, step direction in bit 0 |
| cs_rise | input | 1 | One-cycle strobe: chip select went high |
| wp_n | input | 1 | Write protect, low blocks register stores |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 8 | Read data |
| wip | output | 1 | Nonvolatile store in progress |
| wiper | output | 32 | Wiper codes, channel c in bits 8c+7..8c |
| tap_sel | output | 1024 | One-hot tap selects, 256 per channel |

## Verification
The hardest case to reach is a command that lands inside the busy window. It takes a pending write, a commit strobe, and then a run of commands of each kind issued before the counter runs out. The bench shortens BUSY_CYCLES to 24. It packs a status read, a register read, a blocked register write, a blocked transfer, a wiper write and a step into that window, then counts the high cycles of `wip`. Write-protect is tested at both points where it can act: when the write arrives, and when the strobe arrives after an accepted write.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

    typedef enum logic [1:0] {
        ST_RECALL = 2'd0,
        ST_IDLE   = 2'd1,
        ST_ARMED  = 2'd2,
        ST_BUSY   = 2'd3
    } wrb_state_e;

    typedef enum logic [1:0] {
        RSP_WCR  = 2'd0,
        RSP_DR   = 2'd1,
        RSP_STAT = 2'd2
    } wrb_rsp_e;

endpackage

// File: rtl/wrb_tap_decode.sv
module wrb_tap_decode #(
    parameter int DATA_W = 8,
    localparam int TAPS  = 1 << DATA_W
) (
    input  logic [DATA_W-1:0] code,
    output logic [TAPS-1:0]   taps
);
    for (genvar i = 0; i < TAPS; i++) begin : g_line
        assign taps[i] = (code == DATA_W'(i));
    end
endmodule

// File: rtl/wrb_channel.sv
module wrb_channel #(
    parameter int DATA_W    = 8,
    parameter int NUM_DR    = 4,
    parameter int CH        = 0,
    parameter int INIT_BASE = 64,
    localparam int REG_W    = $clog2(NUM_DR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              recall,
    input  logic              wcr_wr_en,
    input  logic [DATA_W-1:0] wcr_din,
    input  logic              xfr_en,
    input  logic [REG_W-1:0]  xfr_sel,
    input  logic              step_en,
    input  logic              step_up,
    input  logic              commit_en,
    input  logic [REG_W-1:0]  commit_sel,
    input  logic [DATA_W-1:0] commit_data,
    input  logic [REG_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] wcr,
    output logic [DATA_W-1:0] dr_rd
);
    localparam logic [DATA_W-1:0] CODE_MAX = '1;

    logic [DATA_W-1:0] dr_q [NUM_DR];
    logic [DATA_W-1:0] wcr_q;

    for (genvar r = 0; r < NUM_DR; r++) begin : g_dr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dr_q[r] <= DATA_W'(INIT_BASE + CH * 16 + r);
            end else if (commit_en && commit_sel == REG_W'(r)) begin
                dr_q[r] <= commit_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcr_q <= '0;
        end else if (recall) begin
            wcr_q <= dr_q[0];
        end else if (wcr_wr_en) begin
            wcr_q <= wcr_din;
        end else if (xfr_en) begin
            wcr_q <= dr_q[xfr_sel];
        end else if (step_en) begin
            if (step_up && wcr_q != CODE_MAX) begin
                wcr_q <= wcr_q + 1'b1;
            end else if (!step_up && wcr_q != '0) begin
                wcr_q <= wcr_q - 1'b1;
            end
        end
    end

    assign wcr   = wcr_q;
    assign dr_rd = dr_q[rd_sel];
endmodule

// File: rtl/wrb_ctrl.sv
module wrb_ctrl
    import wrb_pkg::*;
#(
    parameter int NUM_POTS    = 4,
    parameter int NUM_DR      = 4,
    parameter int DATA_W      = 8,
    parameter int OP_W        = 4,
    parameter int BUSY_CYCLES = 2000000,
    parameter logic [OP_W-1:0] OP_RD_WCR = 4'h9,
    parameter logic [OP_W-1:0] OP_WR_WCR = 4'hA,
    parameter logic [OP_W-1:0] OP_RD_DR  = 4'hB,
    parameter logic [OP_W-1:0] OP_WR_DR  = 4'hC,
    parameter logic [OP_W-1:0] OP_XFR    = 4'hD,
    parameter logic [OP_W-1:0] OP_GXFR   = 4'h1,
    parameter logic [OP_W-1:0] OP_STEP   = 4'h2,
    parameter logic [OP_W-1:0] OP_RD_ST  = 4'h5,
    localparam int POT_W = $clog2(NUM_POTS),
    localparam int REG_W = $clog2(NUM_DR),
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [OP_W-1:0]     cmd_op,
    input  logic [POT_W-1:0]    cmd_pot,
    input  logic [REG_W-1:0]    cmd_reg,
    input  logic [DATA_W-1:0]   cmd_data,
    input  logic                cs_rise,
    input  logic                wp_n,
    output logic                recall,
    output logic [NUM_POTS-1:0] wcr_wr_en,
    output logic [NUM_POTS-1:0] xfr_en,
    output logic [NUM_POTS-1:0] step_en,
    output logic                step_up,
    output logic [NUM_POTS-1:0] commit_en,
    output logic [REG_W-1:0]    commit_sel,
    output logic [DATA_W-1:0]   commit_data,
    output logic                rd_en,
    output wrb_rsp_e            rd_kind,
    output logic                wip
);
    wrb_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [POT_W-1:0]  pend_pot_q;
    logic [REG_W-1:0]  pend_reg_q;
    logic [DATA_W-1:0] pend_data_q;

    logic cmd_live, nv_free, dr_wr_take, commit_try;

    assign cmd_live   = cmd_valid && (state_q != ST_RECALL);
    assign commit_try = (state_q == ST_ARMED) && cs_rise;
    assign nv_free    = (state_q == ST_IDLE) || ((state_q == ST_ARMED) && !cs_rise);
    assign dr_wr_take = cmd_live && nv_free && (cmd_op == OP_WR_DR) && wp_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_RECALL;
            cnt_q       <= '0;
            pend_pot_q  <= '0;
            pend_reg_q  <= '0;
            pend_data_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (dr_wr_take) begin
                pend_pot_q  <= cmd_pot;
                pend_reg_q  <= cmd_reg;
                pend_data_q <= cmd_data;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RECALL: state_d = ST_IDLE;                 // BOOT_DONE
            ST_IDLE: begin
                if (dr_wr_take) state_d = ST_ARMED;       // ARM
            end
            ST_ARMED: begin
                if (cs_rise) begin
                    if (wp_n) begin
                        state_d = ST_BUSY;                // COMMIT
                        cnt_d   = CNT_W'(BUSY_CYCLES - 1);
                    end else begin
                        state_d = ST_IDLE;                // DISCARD
                    end
                end
            end
            ST_BUSY: begin
                if (cnt_q == '0) state_d = ST_IDLE;       // RELEASE
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        recall      = (state_q == ST_RECALL);
        wip         = (state_q == ST_BUSY);
        step_up     = cmd_data[0];
        commit_sel  = pend_reg_q;
        commit_data = pend_data_q;
        for (int p = 0; p < NUM_POTS; p++) begin
            wcr_wr_en[p] = cmd_live && (cmd_op == OP_WR_WCR) && (cmd_pot == POT_W'(p));
            step_en[p]   = cmd_live && (cmd_op == OP_STEP) && (cmd_pot == POT_W'(p));
            xfr_en[p]    = cmd_live && nv_free &&
                           (((cmd_op == OP_XFR) && (cmd_pot == POT_W'(p))) || (cmd_op == OP_GXFR));
            commit_en[p] = commit_try && wp_n && (pend_pot_q == POT_W'(p));
        end
        rd_en   = cmd_live && ((cmd_op == OP_RD_WCR) || (cmd_op == OP_RD_DR) || (cmd_op == OP_RD_ST));
        rd_kind = RSP_STAT;
        if (cmd_op == OP_RD_WCR)     rd_kind = RSP_WCR;
        else if (cmd_op == OP_RD_DR) rd_kind = RSP_DR;
    end
endmodule

// File: rtl/quad_wiper_bank.sv
module quad_wiper_bank
    import wrb_pkg::*;
#(
    parameter int NUM_POTS    = 4,
    parameter int NUM_DR      = 4,
    parameter int DATA_W      = 8,
    parameter int OP_W        = 4,
    parameter int BUSY_CYCLES = 2000000,
    parameter int INIT_BASE   = 64,
    parameter logic [OP_W-1:0] OP_RD_WCR = 4'h9,
    parameter logic [OP_W-1:0] OP_WR_WCR = 4'hA,
    parameter logic [OP_W-1:0] OP_RD_DR  = 4'hB,
    parameter logic [OP_W-1:0] OP_WR_DR  = 4'hC,
    parameter logic [OP_W-1:0] OP_XFR    = 4'hD,
    parameter logic [OP_W-1:0] OP_GXFR   = 4'h1,
    parameter logic [OP_W-1:0] OP_STEP   = 4'h2,
    parameter logic [OP_W-1:0] OP_RD_ST  = 4'h5,
    localparam int POT_W = $clog2(NUM_POTS),
    localparam int REG_W = $clog2(NUM_DR),
    localparam int TAPS  = 1 << DATA_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic [OP_W-1:0]            cmd_op,
    input  logic [POT_W-1:0]           cmd_pot,
    input  logic [REG_W-1:0]           cmd_reg,
    input  logic [DATA_W-1:0]          cmd_data,
    input  logic                       cs_rise,
    input  logic                       wp_n,
    output logic                       rsp_valid,
    output logic [DATA_W-1:0]          rsp_data,
    output logic                       wip,
    output logic [NUM_POTS*DATA_W-1:0] wiper,
    output logic [NUM_POTS*TAPS-1:0]   tap_sel
);
    logic                recall, step_up, rd_en;
    logic [NUM_POTS-1:0] wcr_wr_en, xfr_en, step_en, commit_en;
    logic [REG_W-1:0]    commit_sel;
    logic [DATA_W-1:0]   commit_data;
    wrb_rsp_e            rd_kind;
    logic [DATA_W-1:0]   wcr_arr [NUM_POTS];
    logic [DATA_W-1:0]   dr_arr  [NUM_POTS];
    logic                rsp_valid_q;
    logic [DATA_W-1:0]   rsp_data_q;

    wrb_ctrl #(
        .NUM_POTS(NUM_POTS), .NUM_DR(NUM_DR), .DATA_W(DATA_W), .OP_W(OP_W),
        .BUSY_CYCLES(BUSY_CYCLES),
        .OP_RD_WCR(OP_RD_WCR), .OP_WR_WCR(OP_WR_WCR), .OP_RD_DR(OP_RD_DR),
        .OP_WR_DR(OP_WR_DR), .OP_XFR(OP_XFR), .OP_GXFR(OP_GXFR),
        .OP_STEP(OP_STEP), .OP_RD_ST(OP_RD_ST)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
        .cs_rise(cs_rise), .wp_n(wp_n), .recall(recall),
        .wcr_wr_en(wcr_wr_en), .xfr_en(xfr_en), .step_en(step_en),
        .step_up(step_up), .commit_en(commit_en), .commit_sel(commit_sel),
        .commit_data(commit_data), .rd_en(rd_en), .rd_kind(rd_kind), .wip(wip)
    );

    for (genvar c = 0; c < NUM_POTS; c++) begin : g_chan
        wrb_channel #(
            .DATA_W(DATA_W), .NUM_DR(NUM_DR), .CH(c), .INIT_BASE(INIT_BASE)
        ) chan_i (
            .clk(clk), .rst_n(rst_n), .recall(recall),
            .wcr_wr_en(wcr_wr_en[c]), .wcr_din(cmd_data),
            .xfr_en(xfr_en[c]), .xfr_sel(cmd_reg),
            .step_en(step_en[c]), .step_up(step_up),
            .commit_en(commit_en[c]), .commit_sel(commit_sel),
            .commit_data(commit_data), .rd_sel(cmd_reg),
            .wcr(wcr_arr[c]), .dr_rd(dr_arr[c])
        );

        wrb_tap_decode #(.DATA_W(DATA_W)) dec_i (
            .code(wcr_arr[c]),
            .taps(tap_sel[c*TAPS +: TAPS])
        );

        assign wiper[c*DATA_W +: DATA_W] = wcr_arr[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= rd_en;
            if (rd_en) begin
                unique case (rd_kind)
                    RSP_WCR: rsp_data_q <= wcr_arr[cmd_pot];
                    RSP_DR:  rsp_data_q <= dr_arr[cmd_pot];
                    default: rsp_data_q <= {{(DATA_W-1){1'b0}}, wip};
                endcase
            end
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/wrb_checker.sv
module wrb_checker #(
    parameter int NUM_POTS    = 4,
    parameter int DATA_W      = 8,
    parameter int BUSY_CYCLES = 2000000,
    localparam int TAPS       = 1 << DATA_W
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cmd_valid,
    input logic                       cs_rise,
    input logic                       wp_n,
    input logic                       rsp_valid,
    input logic                       wip,
    input logic [NUM_POTS*DATA_W-1:0] wiper,
    input logic [NUM_POTS*TAPS-1:0]   tap_sel
);
    int   wip_run_q;
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wip_run_q <= 0;
            age_q     <= '0;
        end else begin
            wip_run_q <= wip ? wip_run_q + 1 : 0;
            if (age_q != 2'd2) age_q <= age_q + 1'b1;
        end
    end

    for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
        AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(tap_sel[p*TAPS +: TAPS]) == 1); // R2
    end

    AST_WIP_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(cs_rise)); // R8

    AST_WIP_NEEDS_WP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wp_n)); // R9

    AST_WIP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> (wip_run_q < BUSY_CYCLES)); // R8

    AST_RSP_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cmd_valid)); // R6

    AST_WIPER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q == 2'd2) && !$stable(wiper)) |-> $past(cmd_valid)); // R3
endmodule

bind quad_wiper_bank wrb_checker #(
    .NUM_POTS(NUM_POTS), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cs_rise(cs_rise),
    .wp_n(wp_n), .rsp_valid(rsp_valid), .wip(wip), .wiper(wiper),
    .tap_sel(tap_sel)
);

// File: tb/quad_wiper_bank_tb_top.sv
module quad_wiper_bank_tb_top;
    localparam int BUSY = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [1:0]  cmd_pot = '0;
    logic [1:0]  cmd_reg = '0;
    logic [7:0]  cmd_data = '0;
    logic        cs_rise = 1'b0;
    logic        wp_n = 1'b1;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic        wip;
    logic [31:0] wiper;
    logic [1023:0] tap_sel;

    int checks = 0, fails = 0, sb_checks = 0, sb_fails = 0;
    int wip_cycles = 0, cyc = 0;
    bit done = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    quad_wiper_bank #(.BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
        .cs_rise(cs_rise), .wp_n(wp_n), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .wip(wip), .wiper(wiper), .tap_sel(tap_sel)
    );

    function automatic logic [7:0] init_val(int ch, int r);
        return 8'(64 + 16 * ch + r);
    endfunction

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     checks + sb_checks, fails + sb_fails);
            $finish;
        end
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_wiper(string req, int ch, logic [7:0] exp);
        check(req, 32'(wiper[ch*8 +: 8]), 32'(exp));
        check("R2", 32'($countones(tap_sel[ch*256 +: 256])), 32'd1);
        check("R2", 32'(tap_sel[ch*256 + int'(exp)]), 32'd1);
    endtask

    task automatic cmd(logic [3:0] op, int pot, int rg, logic [7:0] d);
        @(negedge clk);
        cmd_op = op; cmd_pot = 2'(pot); cmd_reg = 2'(rg); cmd_data = d;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic rd(logic [3:0] op, int pot, int rg, logic [7:0] exp, string req);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        cmd(op, pot, rg, 8'h00);
    endtask

    task automatic pulse_cs();
        @(negedge clk);
        cs_rise = 1'b1;
        @(negedge clk);
        cs_rise = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            sb_checks++;
            if (exp_q.size() == 0) begin
                sb_fails++;
                $display("FAIL R6 actual unexpected response %0h expected none", rsp_data);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rsp_data !== e) begin
                    sb_fails++;
                    $display("FAIL %s actual %0h expected %0h", t, rsp_data, e);
                end
            end
        end
        if (rst_n && wip) wip_cycles++;
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        check("R1", 32'(wip), 32'd0);
        check("R1", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int c = 0; c < 4; c++) check_wiper("R1", c, init_val(c, 0));

        // R3 / R2 extremes
        cmd(4'hA, 2, 0, 8'h00); check_wiper("R3", 2, 8'h00);
        cmd(4'hA, 2, 0, 8'hFF); check_wiper("R3", 2, 8'hFF);
        // R4 saturation and steps
        cmd(4'h2, 2, 0, 8'h01); check_wiper("R4", 2, 8'hFF);
        cmd(4'h2, 2, 0, 8'h00); check_wiper("R4", 2, 8'hFE);
        cmd(4'hA, 2, 0, 8'h00);
        cmd(4'h2, 2, 0, 8'h00); check_wiper("R4", 2, 8'h00);
        cmd(4'h2, 2, 0, 8'h01); check_wiper("R4", 2, 8'h01);
        // R6 reads
        rd(4'h9, 2, 0, 8'h01, "R6");
        rd(4'hB, 3, 2, init_val(3, 2), "R6");
        rd(4'h5, 0, 0, 8'h00, "R6");
        // R5 transfers
        cmd(4'hD, 0, 3, 8'h00); check_wiper("R5", 0, init_val(0, 3));
        cmd(4'h1, 0, 1, 8'h00);
        for (int c = 0; c < 4; c++) check_wiper("R5", c, init_val(c, 1));

        // R7 deferred store, replacement
        cmd(4'hC, 1, 2, 8'hAA);
        rd(4'hB, 1, 2, init_val(1, 2), "R7");
        cmd(4'hC, 1, 2, 8'hBB);
        base = wip_cycles;
        pulse_cs();
        check("R8", 32'(wip), 32'd1);
        rd(4'h5, 0, 0, 8'h01, "R6");
        rd(4'hB, 1, 2, 8'hBB, "R7");
        // R10 blocked while busy
        cmd(4'hC, 0, 0, 8'h11);
        cmd(4'hD, 1, 2, 8'h00); check_wiper("R10", 1, init_val(1, 1));
        cmd(4'hA, 1, 0, 8'h33); check_wiper("R10", 1, 8'h33);
        cmd(4'h2, 1, 0, 8'h01); check_wiper("R10", 1, 8'h34);
        for (int i = 0; i < 100 && wip; i++) @(negedge clk);
        check("R8", 32'(wip_cycles - base), 32'(BUSY));
        rd(4'hB, 0, 0, init_val(0, 0), "R10");
        // R11 stray strobe
        pulse_cs();
        check("R11", 32'(wip), 32'd0);
        rd(4'hB, 0, 0, init_val(0, 0), "R11");

        // R9 protect at write time
        wp_n = 1'b0;
        cmd(4'hC, 3, 0, 8'h99);
        pulse_cs();
        check("R9", 32'(wip), 32'd0);
        rd(4'hB, 3, 0, init_val(3, 0), "R9");
        cmd(4'hA, 3, 0, 8'h12); check_wiper("R9", 3, 8'h12);
        // R9 protect at strobe time
        wp_n = 1'b1;
        cmd(4'hC, 3, 1, 8'h77);
        wp_n = 1'b0;
        pulse_cs();
        check("R9", 32'(wip), 32'd0);
        wp_n = 1'b1;
        rd(4'hB, 3, 1, init_val(3, 1), "R9");
        // R5 transfer of committed value
        cmd(4'hD, 1, 2, 8'h00); check_wiper("R5", 1, 8'hBB);

        repeat (3) @(negedge clk);
        check("R6", 32'(exp_q.size()), 32'd0);
        finish_up();
    end
endmodule